// File: doc/BRIEF.md
# Multi-Locality Access Arbiter

This block decides which of several prioritised localities (five by default, numbered 0 to 4, with 4 the highest) owns a shared secure device at any moment. Each locality has an 8-bit access register. Software writes it through a simple register port made of a write strobe, a locality index and a data byte. Any locality's register can be read back at any time through a combinational read port.

A locality asks for the device by setting its request bit. When nobody owns the device, the highest-numbered requester is granted on the next clock. The owner gives the device back by writing its active bit. A higher-numbered locality may seize the device from the current owner; the loser then carries a sticky flag that records the loss. The block also holds a platform establishment flag, which only the upper localities may clear. Downstream command logic receives the current owner index and a grant-valid signal.

Field positions in the access register: bit 7 valid, bit 5 active, bit 4 been-seized, bit 3 seize (write only, reads 0), bit 2 pending, bit 1 request, bit 0 establishment. A write whose locality index is outside the locality range has no effect, and reading such an index returns 0.

Top module: `loc_arb_top`

## Requirements
- R1: After reset no locality owns the device (`grant_valid` = 0), no request or been-seized bit is set, and the establishment flag is 1, so every locality reads 8'h81.
- R2: Bit 7 of every in-range locality register always reads 1.
- R3: A write with bit 1 set marks the writing locality as requesting, so its bit 1 reads 1. Every other locality then reads bit 2 (pending) as 1 while that request is outstanding.
- R4: While no locality is active and at least one request exists, the next clock edge grants the highest-numbered requester, sets `grant_valid` and clears the winner's bit 1.
- R5: A write of 1 to bit 5 by the owning locality releases the device on that edge. Any outstanding request is granted on the following edge.
- R6: A write of 1 to bit 5 by a locality that is not the owner changes nothing.
- R7: A write of 1 to bit 3 by a locality numbered above the current owner makes the writer the owner on that edge, clears the writer's request, and sets bit 4 of the former owner.
- R8: A write of 1 to bit 3 is ignored when the writer is numbered at or below the current owner, or when no locality is active.
- R9: Bit 4 stays set until the same locality writes 1 to bit 4. Writes by other localities, and writes with bit 4 at 0, leave it set.
- R10: A write of 1 to bit 0 from locality 3 or above clears the establishment flag, which then reads 0 in every register until reset. The same write from a lower locality has no effect.
- R11: A request write (bit 1) from the locality that currently owns the device is ignored.
- R12: `owner_loc` and `grant_valid` report the owner. Bit 5 reads 1 only in the owner's register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for one cycle |
| wr_loc | input | 3 | Locality index of the write |
| wr_data | input | 8 | Write data byte |
| rd_loc | input | 3 | Locality index to read |
| rd_data | output | 8 | Access register view of `rd_loc` |
| owner_loc | output | 3 | Index of the owning locality |
| grant_valid | output | 1 | A locality owns the device |

## Verification
The assertions assume the write inputs are settled at every rising edge and that each write is a one-cycle strobe, so each transition happens on exactly one edge. The stimulus changes inputs only on falling edges and returns `wr_en` to 0 after every write, which keeps it within that assumption. The ordering cases are stepped through one edge at a time: relinquish followed by a grant, a seize while other requests are outstanding, and an ignored seize with no owner.

// File: rtl/loc_arb_pkg.sv
`timescale 1ns/1ps
package loc_arb_pkg;
   localparam int unsigned REG_W      = 8;
   localparam int unsigned BIT_VALID  = 7;
   localparam int unsigned BIT_ACTIVE = 5;
   localparam int unsigned BIT_SEIZED = 4;
   localparam int unsigned BIT_SEIZE  = 3;
   localparam int unsigned BIT_PEND   = 2;
   localparam int unsigned BIT_REQ    = 1;
   localparam int unsigned BIT_ESTAB  = 0;
endpackage

// File: rtl/loc_arb_pick.sv
`timescale 1ns/1ps
// Highest-index picker over a request vector.
module loc_arb_pick #(
   parameter int unsigned NUM_LOC = 5,
   parameter int unsigned LOC_W   = 3
) (
   input  logic [NUM_LOC-1:0] req,
   output logic               any,
   output logic [LOC_W-1:0]   idx
);
   always_comb begin
      idx = '0;
      for (int i = 0; i < NUM_LOC; i++) begin
         if (req[i]) idx = LOC_W'(i);
      end
   end
   assign any = |req;
endmodule

// File: rtl/loc_arb_wr_dec.sv
`timescale 1ns/1ps
// Turns one register write into per-locality strobes, judged against the current owner.
module loc_arb_wr_dec
   import loc_arb_pkg::*;
#(
   parameter int unsigned NUM_LOC       = 5,
   parameter int unsigned LOC_W         = 3,
   parameter int unsigned ESTAB_MIN_LOC = 3
) (
   input  logic               wr_en,
   input  logic [LOC_W-1:0]   wr_loc,
   input  logic [REG_W-1:0]   wr_data,
   input  logic               owner_valid,
   input  logic [LOC_W-1:0]   owner_loc,
   output logic [NUM_LOC-1:0] req_set,
   output logic [NUM_LOC-1:0] seized_clr,
   output logic               relinquish,
   output logic               seize_take,
   output logic               estab_clr
);
   localparam logic [LOC_W:0]   LOC_LIMIT = (LOC_W+1)'(NUM_LOC);
   localparam logic [LOC_W-1:0] ESTAB_MIN = LOC_W'(ESTAB_MIN_LOC);

   logic loc_ok;
   assign loc_ok = wr_en && ({1'b0, wr_loc} < LOC_LIMIT);

   for (genvar i = 0; i < NUM_LOC; i++) begin : g_loc
      logic hit;
      assign hit           = loc_ok && (wr_loc == LOC_W'(i));
      assign req_set[i]    = hit && wr_data[BIT_REQ] && !(owner_valid && owner_loc == LOC_W'(i));
      assign seized_clr[i] = hit && wr_data[BIT_SEIZED];
   end

   assign relinquish = loc_ok && wr_data[BIT_ACTIVE] && owner_valid && (wr_loc == owner_loc);
   assign seize_take = loc_ok && wr_data[BIT_SEIZE] && owner_valid && (wr_loc > owner_loc);
   assign estab_clr  = loc_ok && wr_data[BIT_ESTAB] && (wr_loc >= ESTAB_MIN);
endmodule

// File: rtl/loc_arb_view.sv
`timescale 1ns/1ps
// Builds each locality's access register image and selects one for reading.
module loc_arb_view
   import loc_arb_pkg::*;
#(
   parameter int unsigned NUM_LOC = 5,
   parameter int unsigned LOC_W   = 3
) (
   input  logic               owner_valid,
   input  logic [LOC_W-1:0]   owner_loc,
   input  logic [NUM_LOC-1:0] req,
   input  logic [NUM_LOC-1:0] seized,
   input  logic               estab,
   input  logic [LOC_W-1:0]   rd_loc,
   output logic [REG_W-1:0]   rd_data
);
   logic [REG_W-1:0] image [NUM_LOC];

   for (genvar i = 0; i < NUM_LOC; i++) begin : g_img
      logic [NUM_LOC-1:0] others;
      assign others = req & ~(NUM_LOC'(1) << i);
      always_comb begin
         image[i]             = '0;
         image[i][BIT_VALID]  = 1'b1;
         image[i][BIT_ACTIVE] = owner_valid && (owner_loc == LOC_W'(i));
         image[i][BIT_SEIZED] = seized[i];
         image[i][BIT_PEND]   = |others;
         image[i][BIT_REQ]    = req[i];
         image[i][BIT_ESTAB]  = estab;
      end
   end

   always_comb begin
      rd_data = '0;
      for (int i = 0; i < NUM_LOC; i++) begin
         if (rd_loc == LOC_W'(i)) rd_data = image[i];
      end
   end
endmodule

// File: rtl/loc_arb_top.sv
`timescale 1ns/1ps
module loc_arb_top
   import loc_arb_pkg::*;
#(
   parameter int unsigned NUM_LOC       = 5,
   parameter int unsigned ESTAB_MIN_LOC = 3,
   localparam int unsigned LOC_W        = $clog2(NUM_LOC)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [LOC_W-1:0] wr_loc,
   input  logic [REG_W-1:0] wr_data,
   input  logic [LOC_W-1:0] rd_loc,
   output logic [REG_W-1:0] rd_data,
   output logic [LOC_W-1:0] owner_loc,
   output logic             grant_valid
);
   if (NUM_LOC < 2) begin : g_bad_num
      $error("loc_arb_top: NUM_LOC must be at least 2");
   end
   if (ESTAB_MIN_LOC >= NUM_LOC) begin : g_bad_estab
      $error("loc_arb_top: ESTAB_MIN_LOC must name an existing locality");
   end

   logic               owner_valid_q;
   logic [LOC_W-1:0]   owner_q;
   logic [NUM_LOC-1:0] req_q;
   logic [NUM_LOC-1:0] seized_q;
   logic               estab_q;

   logic [NUM_LOC-1:0] req_set, seized_clr, req_clr, seized_mark;
   logic               relinquish, seize_take, estab_clr;
   logic               any_req, grant;
   logic [LOC_W-1:0]   pick;

   loc_arb_wr_dec #(
      .NUM_LOC(NUM_LOC), .LOC_W(LOC_W), .ESTAB_MIN_LOC(ESTAB_MIN_LOC)
   ) u_dec (
      .wr_en(wr_en), .wr_loc(wr_loc), .wr_data(wr_data),
      .owner_valid(owner_valid_q), .owner_loc(owner_q),
      .req_set(req_set), .seized_clr(seized_clr),
      .relinquish(relinquish), .seize_take(seize_take), .estab_clr(estab_clr)
   );

   loc_arb_pick #(.NUM_LOC(NUM_LOC), .LOC_W(LOC_W)) u_pick (
      .req(req_q), .any(any_req), .idx(pick)
   );

   loc_arb_view #(.NUM_LOC(NUM_LOC), .LOC_W(LOC_W)) u_view (
      .owner_valid(owner_valid_q), .owner_loc(owner_q), .req(req_q),
      .seized(seized_q), .estab(estab_q), .rd_loc(rd_loc), .rd_data(rd_data)
   );

   assign grant = !owner_valid_q && any_req;

   for (genvar i = 0; i < NUM_LOC; i++) begin : g_mask
      assign req_clr[i]     = (seize_take && wr_loc == LOC_W'(i)) ||
                              (grant && pick == LOC_W'(i));
      assign seized_mark[i] = seize_take && owner_q == LOC_W'(i);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         owner_valid_q <= 1'b0;
         owner_q       <= '0;
         req_q         <= '0;
         seized_q      <= '0;
         estab_q       <= 1'b1;
      end else begin
         req_q    <= (req_q | req_set) & ~req_clr;
         seized_q <= (seized_q & ~seized_clr) | seized_mark;
         if (estab_clr) estab_q <= 1'b0;
         if (seize_take) begin
            owner_q <= wr_loc;
         end else if (relinquish) begin
            owner_valid_q <= 1'b0;
         end else if (grant) begin
            owner_valid_q <= 1'b1;
            owner_q       <= pick;
         end
      end
   end

   assign owner_loc   = owner_q;
   assign grant_valid = owner_valid_q;

   // Assertions
   assert_grant_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!grant_valid && req_q != '0) |=> grant_valid);

   assert_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_data[BIT_ACTIVE] && grant_valid && wr_loc == owner_loc) |=> !grant_valid);

   assert_seize_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_data[BIT_SEIZE] && grant_valid && wr_loc > owner_loc &&
       {1'b0, wr_loc} < (LOC_W+1)'(NUM_LOC))
      |=> (grant_valid && owner_loc == $past(wr_loc)));

   assert_low_seize_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_data[BIT_SEIZE] && !wr_data[BIT_ACTIVE] && grant_valid && wr_loc <= owner_loc)
      |=> (grant_valid && $stable(owner_loc)));

   assert_idle_seize_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_data[BIT_SEIZE] && !grant_valid && req_q == '0) |=> !grant_valid);

   assert_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en || !wr_data[BIT_SEIZED]) |=> ((seized_q & $past(seized_q)) == $past(seized_q)));

   assert_estab_once_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !estab_q |=> !estab_q);

   assert_estab_guard_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_loc < LOC_W'(ESTAB_MIN_LOC)) |=> $stable(estab_q));

   assert_owner_range_R12: assert property (@(posedge clk) disable iff (!rst_n)
      grant_valid |-> ({1'b0, owner_loc} < (LOC_W+1)'(NUM_LOC)));
endmodule

// File: tb/loc_arb_top_bench.sv
`timescale 1ns/1ps
module loc_arb_top_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [2:0] wr_loc = '0;
   logic [7:0] wr_data = '0;
   logic [2:0] rd_loc = '0;
   logic [7:0] rd_data;
   logic [2:0] owner_loc;
   logic       grant_valid;

   int checks = 0;
   int failures = 0;
   int cycles = 0;

   always #10 clk = ~clk;

   loc_arb_top u_loc_arb_top (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_loc(wr_loc), .wr_data(wr_data),
      .rd_loc(rd_loc), .rd_data(rd_data), .owner_loc(owner_loc), .grant_valid(grant_valid)
   );

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles > 20000) begin
         failures = failures + 1;
         $display("FAIL watchdog: run hung, actual cycles=%0d expected below 20000", cycles);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic wr(input int loc, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_loc = 3'(loc); wr_data = d;
      @(negedge clk);
      wr_en = 1'b0; wr_data = '0;
   endtask

   task automatic rd(input int loc, output logic [7:0] v);
      rd_loc = 3'(loc);
      #1 v = rd_data;
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic t_reset();
      logic [7:0] v;
      check("R1 grant_valid", int'(grant_valid), 0);
      for (int i = 0; i < 5; i++) begin
         rd(i, v);
         check("R1 R2 reset image", int'(v), 'h81);
      end
   endtask

   task automatic t_request_grant();
      logic [7:0] v;
      wr(1, 8'h02);
      rd(1, v); check("R3 own request bit", int'(v), 'h83);
      rd(0, v); check("R3 pending seen by other", int'(v), 'h85);
      tick();
      check("R4 grant valid", int'(grant_valid), 1);
      check("R4 R12 owner index", int'(owner_loc), 1);
      rd(1, v); check("R4 R12 owner image, request cleared", int'(v), 'hA1);
      rd(3, v); check("R12 non-owner not active", int'(v[5]), 0);
   endtask

   task automatic t_release();
      logic [7:0] v;
      wr(0, 8'h02);
      wr(2, 8'h02);
      rd(1, v); check("R3 owner sees pending", int'(v), 'hA5);
      wr(0, 8'h20);
      check("R6 non-owner release ignored", int'(owner_loc), 1);
      check("R6 still granted", int'(grant_valid), 1);
      wr(1, 8'h20);
      check("R5 released", int'(grant_valid), 0);
      tick();
      check("R5 R4 highest requester wins", int'(owner_loc), 2);
      check("R5 granted again", int'(grant_valid), 1);
      rd(0, v); check("R4 loser keeps request", int'(v), 'h83);
   endtask

   task automatic t_owner_request();
      logic [7:0] v;
      wr(2, 8'h02);
      rd(2, v); check("R11 owner request ignored", int'(v[1]), 0);
      rd(0, v); check("R11 no pending from owner", int'(v[2]), 0);
   endtask

   task automatic t_seize();
      logic [7:0] v;
      wr(1, 8'h08);
      check("R8 lower seize ignored", int'(owner_loc), 2);
      wr(2, 8'h08);
      check("R8 equal seize ignored", int'(owner_loc), 2);
      rd(2, v); check("R8 no seized flag", int'(v[4]), 0);
      wr(4, 8'h0A);
      check("R7 seize takes owner", int'(owner_loc), 4);
      check("R7 still granted", int'(grant_valid), 1);
      rd(2, v); check("R7 loser seized flag", int'(v), 'h95);
      rd(4, v); check("R7 seizer request cleared", int'(v[1]), 0);
      wr(2, 8'h00);
      rd(2, v); check("R9 zero write keeps flag", int'(v[4]), 1);
      wr(3, 8'h10);
      rd(2, v); check("R9 other locality keeps flag", int'(v[4]), 1);
      wr(2, 8'h10);
      rd(2, v); check("R9 own write clears flag", int'(v[4]), 0);
   endtask

   task automatic t_idle_seize();
      wr(4, 8'h20);
      tick();
      check("R4 waiting request granted", int'(owner_loc), 0);
      wr(0, 8'h20);
      check("R5 idle after release", int'(grant_valid), 0);
      wr(3, 8'h08);
      tick();
      check("R8 seize with no owner ignored", int'(grant_valid), 0);
   endtask

   task automatic t_estab();
      logic [7:0] v;
      wr(2, 8'h01);
      rd(0, v); check("R10 low locality cannot clear", int'(v[0]), 1);
      wr(3, 8'h01);
      for (int i = 0; i < 5; i++) begin
         rd(i, v); check("R10 flag cleared everywhere", int'(v), 'h80);
      end
      wr(4, 8'h00);
      rd(4, v); check("R10 flag stays clear", int'(v[0]), 0);
      rd(4, v); check("R2 valid bit", int'(v[7]), 1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_request_grant();
      t_release();
      t_owner_request();
      t_seize();
      t_idle_seize();
      t_estab();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule